// File: doc/BRIEF.md
# Bridge Error and Abort Handler

This block decides how a PCI-to-PCI bridge reacts when a transaction it forwarded ends in a master-abort, and when a parity error is seen on the secondary bus. It holds the error-related control bits of the bridge control register. From those bits, the PCI-X mode flag and a short descriptor of the aborted transaction, it picks the completion action. The action is one of four: return all-ones data, discard the write data, signal target-abort, or answer with a split completion message. It also raises an active-low one-cycle pulse on primary SERR# when an error is to be reported upward.

It records three sticky status bits: master-abort seen, secondary parity error detected, and secondary SERR# received. Software clears them with a write-one-to-clear strobe. The block also drives the secondary bus reset output from a control bit. Bus protocol sequencing, data buffering and configuration-space decode belong to neighbouring blocks. Those blocks present an aborted transaction as a one-cycle `ma_valid` strobe and take back the registered completion action one cycle later.

Top module: `bridge_err_ctrl`

## Requirements
- R1: With the abort-report bit (control bit 5) at 0, a master-aborted read (`ma_is_write`=0) that does not take the split path completes with `cmpl_action`=0 (return data) and `cmpl_data` all ones, and no SERR# pulse comes from it.
- R2: With the abort-report bit at 0, a master-aborted write that does not take the split path completes with `cmpl_action`=1 (discard), `cmpl_data` zero, and no SERR# pulse.
- R3: With the abort-report bit at 1, a non-posted transaction in conventional mode whose initiator can be target-aborted (`ma_tabort_ok`=1) completes with `cmpl_action`=2 (target-abort), and no SERR# pulse comes from it.
- R4: With the abort-report bit at 1, a master-abort that takes neither the split nor the target-abort path completes as in R1/R2. It also drives a primary SERR# pulse when the SERR enable bit (control bit 1) is 1, and no pulse when that bit is 0.
- R5: With `pcix_mode`=1, a non-posted master-abort completes with `cmpl_action`=3 (split completion) whatever the abort-report bit, with zero data and no SERR# pulse. A posted write in PCI-X mode follows R2/R4.
- R6: A `perr_strobe` always sets status bit 1 (secondary parity error). `perr_report` pulses one cycle later only while the parity response bit (control bit 0) is 1.
- R7: A falling edge of `sec_serr_n` always sets status bit 2. It produces a primary SERR# pulse one cycle later only while the SERR enable bit is 1. A level held low gives no further pulses.
- R8: `pri_serr_n` is low for exactly one cycle per reporting cycle. A master-abort report and a secondary SERR# edge in the same cycle give a single pulse.
- R9: Status bits are sticky: bit 0 sets on every `ma_valid`. A 1 in `sts_clr` clears the matching bit, except that a set event in the same cycle wins.
- R10: `sec_rst_n` is low while control bit 6 is 1 and high while it is 0. It is high after reset.
- R11: `ctl_rd` returns the stored bits 0, 1, 5 and 6 as written. Bits 2, 3, 4 and 7 always read 0, bit 4 included, even after a write of all ones. The write takes effect on the next cycle, and decisions in the write cycle use the old bits.
- R12: `cmpl_valid` is a one-cycle pulse in the cycle after each `ma_valid`, including back-to-back strobes. After reset all status, `cmpl_valid` and `perr_report` are 0 and `pri_serr_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Primary clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr_en | input | 1 | Write strobe for the control bits |
| ctl_wr_data | input | 8 | Control write data |
| ctl_rd | output | 8 | Control readback |
| pcix_mode | input | 1 | 1 = bridge runs in PCI-X mode |
| ma_valid | input | 1 | One-cycle strobe: a forwarded transaction master-aborted |
| ma_is_write | input | 1 | Aborted transaction is a write |
| ma_posted | input | 1 | Aborted transaction is posted |
| ma_tabort_ok | input | 1 | Initiator can still be target-aborted |
| perr_strobe | input | 1 | Secondary address or data parity error seen |
| sec_serr_n | input | 1 | Secondary SERR#, active low, synchronous |
| sts_clr | input | 3 | Write-one-to-clear strobes for the status bits |
| cmpl_valid | output | 1 | Completion action valid |
| cmpl_action | output | 2 | 0 data, 1 discard, 2 target-abort, 3 split completion |
| cmpl_data | output | DATA_W | Data returned with the completion |
| pri_serr_n | output | 1 | Primary SERR#, active-low pulse |
| perr_report | output | 1 | Parity error reporting pulse |
| sts | output | 3 | Sticky status: 0 master-abort, 1 parity, 2 SERR received |
| sec_rst_n | output | 1 | Secondary bus reset, active low |

## Verification
Two pairs of functions can land in one cycle. A master-abort that asks for SERR# can coincide with a falling edge on secondary SERR#. A status set event can coincide with its write-one-to-clear strobe. The bench drives both pairs in the same cycle. It also drives the abort with a control write that changes the abort-report bit, and checks that the old setting decides. A behavioural model tracks every output each cycle. It expects a single one-cycle SERR# pulse for the merged report and a status bit that stays set.

// File: rtl/bec_pkg.sv
// Package: shared encodings for the bridge error and abort handler.
// Assumes: control and status bit positions are fixed by the register
// layout that software decodes.
package bec_pkg;

    typedef enum logic [1:0] {
        ACT_ONES    = 2'd0,
        ACT_DISCARD = 2'd1,
        ACT_TABORT  = 2'd2,
        ACT_SPLIT   = 2'd3
    } cmpl_act_e;

    localparam int CTL_W        = 8;
    localparam int CB_PERR_RESP = 0;
    localparam int CB_SERR_EN   = 1;
    localparam int CB_RSVD      = 4;
    localparam int CB_ABORT_RPT = 5;
    localparam int CB_SEC_RST   = 6;

    localparam int NUM_STS      = 3;
    localparam int ST_MA        = 0;
    localparam int ST_SEC_PERR  = 1;
    localparam int ST_SERR_RCVD = 2;

    localparam logic [CTL_W-1:0] CTL_KEEP_MASK =
        CTL_W'((1 << CB_PERR_RESP) | (1 << CB_SERR_EN) |
               (1 << CB_ABORT_RPT) | (1 << CB_SEC_RST));

endpackage

// File: rtl/bec_ctl_reg.sv
// Module: bec_ctl_reg
// Holds the error-related control bits. Only the bits in CTL_KEEP_MASK
// have storage; every other bit, the reserved one included, reads 0.
// Assumes: a single write strobe, new value visible the next cycle.
module bec_ctl_reg
    import bec_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wr_data,
    output logic [CTL_W-1:0] rd,
    output logic             perr_resp,
    output logic             serr_en,
    output logic             abort_rpt,
    output logic             sec_rst_req
);

    for (genvar b = 0; b < CTL_W; b++) begin : g_bit
        if (CTL_KEEP_MASK[b]) begin : g_store
            logic bit_q;
            // Stored control bit: cleared by reset, loaded on a write.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    bit_q <= 1'b0;
                else if (wr_en)
                    bit_q <= wr_data[b];
            end
            assign rd[b] = bit_q;
        end else begin : g_zero
            assign rd[b] = 1'b0;
        end
    end

    assign perr_resp   = rd[CB_PERR_RESP];
    assign serr_en     = rd[CB_SERR_EN];
    assign abort_rpt   = rd[CB_ABORT_RPT];
    assign sec_rst_req = rd[CB_SEC_RST];

endmodule

// File: rtl/bec_abort_resolve.sv
// Module: bec_abort_resolve
// Chooses the completion action for a master-aborted transaction and
// registers it for one cycle. Also flags, combinationally, whether the
// abort must be reported through SERR#.
// Assumes: ma_valid is a one-cycle strobe per aborted transaction.
module bec_abort_resolve
    import bec_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ma_valid,
    input  logic              ma_is_write,
    input  logic              ma_posted,
    input  logic              ma_tabort_ok,
    input  logic              pcix_mode,
    input  logic              abort_rpt,
    input  logic              serr_en,
    output logic              ma_serr_req,
    output logic              cmpl_valid,
    output cmpl_act_e         cmpl_action,
    output logic [DATA_W-1:0] cmpl_data
);

    localparam logic [DATA_W-1:0] ALL_ONES = {DATA_W{1'b1}};

    cmpl_act_e act_d;
    logic      use_split;
    logic      use_tabort;

    // Action selection: split first, then target-abort, then data path.
    always_comb begin
        use_split  = pcix_mode && !ma_posted;
        use_tabort = abort_rpt && ma_tabort_ok && !ma_posted;
        if (use_split)
            act_d = ACT_SPLIT;
        else if (use_tabort)
            act_d = ACT_TABORT;
        else if (ma_is_write)
            act_d = ACT_DISCARD;
        else
            act_d = ACT_ONES;
    end

    // SERR# request: report mode on, no in-band way to signal the abort.
    always_comb begin
        ma_serr_req = ma_valid && abort_rpt && serr_en && !use_split && !use_tabort;
    end

    // Completion register: one-cycle valid with action and data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmpl_valid  <= 1'b0;
            cmpl_action <= ACT_ONES;
            cmpl_data   <= '0;
        end else begin
            cmpl_valid <= ma_valid;
            if (ma_valid) begin
                cmpl_action <= act_d;
                cmpl_data   <= (act_d == ACT_ONES) ? ALL_ONES : '0;
            end
        end
    end

endmodule

// File: rtl/bec_report.sv
// Module: bec_report
// Detects falling edges of secondary SERR#, merges every reporting source
// into one primary SERR# pulse per cycle, and issues the parity reporting
// pulse.
// Assumes: sec_serr_n is already synchronous to the primary clock.
module bec_report (
    input  logic clk,
    input  logic rst_n,
    input  logic sec_serr_n,
    input  logic ma_serr_req,
    input  logic serr_en,
    input  logic perr_strobe,
    input  logic perr_resp,
    output logic sec_serr_fall,
    output logic pri_serr_n,
    output logic perr_report
);

    logic sec_serr_q;

    // Previous secondary SERR# level, idle high after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sec_serr_q <= 1'b1;
        else
            sec_serr_q <= sec_serr_n;
    end

    assign sec_serr_fall = sec_serr_q && !sec_serr_n;

    // Primary SERR#: one low cycle for any reporting cause this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pri_serr_n <= 1'b1;
        else
            pri_serr_n <= !(ma_serr_req || (sec_serr_fall && serr_en));
    end

    // Parity report pulse, gated by the response enable.
    always_ff @(posedge clk) begin
        if (!rst_n)
            perr_report <= 1'b0;
        else
            perr_report <= perr_strobe && perr_resp;
    end

endmodule

// File: rtl/bec_status.sv
// Module: bec_status
// Sticky status bits with write-one-to-clear. A set event in the same
// cycle as a clear keeps the bit set.
// Assumes: set and clear are single-cycle strobes.
module bec_status
    import bec_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_STS-1:0] set_ev,
    input  logic [NUM_STS-1:0] clr,
    output logic [NUM_STS-1:0] sts
);

    for (genvar i = 0; i < NUM_STS; i++) begin : g_sts
        // Status bit i: set wins over clear, otherwise hold.
        always_ff @(posedge clk) begin
            if (!rst_n)
                sts[i] <= 1'b0;
            else if (set_ev[i])
                sts[i] <= 1'b1;
            else if (clr[i])
                sts[i] <= 1'b0;
        end
    end

endmodule

// File: rtl/bridge_err_ctrl.sv
// Module: bridge_err_ctrl (top)
// Error and abort handling for a PCI-to-PCI bridge: control bits, master-
// abort completion choice, SERR# and parity reporting, sticky status and
// secondary reset.
// Assumes: all inputs synchronous to clk; neighbours handle the bus
// protocol and consume the completion one cycle after ma_valid.
module bridge_err_ctrl
    import bec_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctl_wr_en,
    input  logic [CTL_W-1:0]   ctl_wr_data,
    output logic [CTL_W-1:0]   ctl_rd,
    input  logic               pcix_mode,
    input  logic               ma_valid,
    input  logic               ma_is_write,
    input  logic               ma_posted,
    input  logic               ma_tabort_ok,
    input  logic               perr_strobe,
    input  logic               sec_serr_n,
    input  logic [NUM_STS-1:0] sts_clr,
    output logic               cmpl_valid,
    output logic [1:0]         cmpl_action,
    output logic [DATA_W-1:0]  cmpl_data,
    output logic               pri_serr_n,
    output logic               perr_report,
    output logic [NUM_STS-1:0] sts,
    output logic               sec_rst_n
);

    logic         perr_resp;
    logic         serr_en;
    logic         abort_rpt;
    logic         sec_rst_req;
    logic         ma_serr_req;
    logic         sec_serr_fall;
    cmpl_act_e    act_q;
    logic [NUM_STS-1:0] set_ev;

    bec_ctl_reg i_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (ctl_wr_en),
        .wr_data     (ctl_wr_data),
        .rd          (ctl_rd),
        .perr_resp   (perr_resp),
        .serr_en     (serr_en),
        .abort_rpt   (abort_rpt),
        .sec_rst_req (sec_rst_req)
    );

    bec_abort_resolve #(.DATA_W(DATA_W)) i_abort (
        .clk          (clk),
        .rst_n        (rst_n),
        .ma_valid     (ma_valid),
        .ma_is_write  (ma_is_write),
        .ma_posted    (ma_posted),
        .ma_tabort_ok (ma_tabort_ok),
        .pcix_mode    (pcix_mode),
        .abort_rpt    (abort_rpt),
        .serr_en      (serr_en),
        .ma_serr_req  (ma_serr_req),
        .cmpl_valid   (cmpl_valid),
        .cmpl_action  (act_q),
        .cmpl_data    (cmpl_data)
    );

    bec_report i_rep (
        .clk           (clk),
        .rst_n         (rst_n),
        .sec_serr_n    (sec_serr_n),
        .ma_serr_req   (ma_serr_req),
        .serr_en       (serr_en),
        .perr_strobe   (perr_strobe),
        .perr_resp     (perr_resp),
        .sec_serr_fall (sec_serr_fall),
        .pri_serr_n    (pri_serr_n),
        .perr_report   (perr_report)
    );

    // Status set sources in bit order of the status register.
    always_comb begin
        set_ev               = '0;
        set_ev[ST_MA]        = ma_valid;
        set_ev[ST_SEC_PERR]  = perr_strobe;
        set_ev[ST_SERR_RCVD] = sec_serr_fall;
    end

    bec_status i_sts (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_ev (set_ev),
        .clr    (sts_clr),
        .sts    (sts)
    );

    assign cmpl_action = act_q;
    assign sec_rst_n   = !sec_rst_req;

endmodule

// File: rtl/bec_checker.sv
// Module: bec_checker
// Temporal properties of bridge_err_ctrl, attached by bind.
module bec_checker
    import bec_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ctl_wr_en,
    input logic [CTL_W-1:0]   ctl_wr_data,
    input logic [CTL_W-1:0]   ctl_rd,
    input logic               pcix_mode,
    input logic               ma_valid,
    input logic               ma_is_write,
    input logic               ma_posted,
    input logic               ma_tabort_ok,
    input logic               perr_strobe,
    input logic               sec_serr_n,
    input logic [NUM_STS-1:0] sts_clr,
    input logic               cmpl_valid,
    input logic [1:0]         cmpl_action,
    input logic [DATA_W-1:0]  cmpl_data,
    input logic               pri_serr_n,
    input logic               perr_report,
    input logic [NUM_STS-1:0] sts,
    input logic               sec_rst_n
);

    assert_ones_data_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (ma_valid && !ctl_rd[CB_ABORT_RPT] && !ma_is_write && !pcix_mode)
        |=> (cmpl_action == 2'd0 && cmpl_data == {DATA_W{1'b1}}));

    assert_discard_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ma_valid && !ctl_rd[CB_ABORT_RPT] && ma_is_write && !pcix_mode)
        |=> (cmpl_action == 2'd1));

    assert_tabort_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ma_valid && ctl_rd[CB_ABORT_RPT] && !pcix_mode && !ma_posted && ma_tabort_ok)
        |=> (cmpl_action == 2'd2));

    assert_split_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ma_valid && pcix_mode && !ma_posted) |=> (cmpl_action == 2'd3 && cmpl_data == '0));

    assert_perr_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        perr_strobe |=> sts[ST_SEC_PERR]);

    assert_serr_fwd_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sec_serr_n) && ctl_rd[CB_SERR_EN]) |=> !pri_serr_n);

    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_clr[ST_MA] && !ma_valid) |=> !sts[ST_MA]);

    assert_sec_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr_en && ctl_wr_data[CB_SEC_RST]) |=> !sec_rst_n);

    assert_valid_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ma_valid |=> cmpl_valid);

endmodule

bind bridge_err_ctrl bec_checker #(.DATA_W(DATA_W)) i_bec_checker (.*);

// File: tb/test_bridge_err_ctrl.sv
// Bench for bridge_err_ctrl: a behavioural model updated on every rising
// edge and compared with all outputs on every falling edge.
module test_bridge_err_ctrl;

    localparam int DW = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr_en = 1'b0;
    logic [7:0]  ctl_wr_data = '0;
    logic [7:0]  ctl_rd;
    logic        pcix_mode = 1'b0;
    logic        ma_valid = 1'b0;
    logic        ma_is_write = 1'b0;
    logic        ma_posted = 1'b0;
    logic        ma_tabort_ok = 1'b0;
    logic        perr_strobe = 1'b0;
    logic        sec_serr_n = 1'b1;
    logic [2:0]  sts_clr = '0;
    logic        cmpl_valid;
    logic [1:0]  cmpl_action;
    logic [DW-1:0] cmpl_data;
    logic        pri_serr_n;
    logic        perr_report;
    logic [2:0]  sts;
    logic        sec_rst_n;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    bridge_err_ctrl #(.DATA_W(DW)) i_bridge_err_ctrl (.*);

    // Reference model state
    int m_ctl = 0;
    int m_valid = 0, m_act = 0, m_serr_n = 1, m_perr_rep = 0, m_secq = 1;
    int m_sts[3] = '{0, 0, 0};
    longint m_data = 0;

    always @(posedge clk) begin
        int act;
        int rpt, sen, presp, ma_serr, fall;
        if (!rst_n) begin
            m_ctl = 0; m_valid = 0; m_act = 0; m_serr_n = 1; m_perr_rep = 0;
            m_secq = 1; m_data = 0;
            foreach (m_sts[i]) m_sts[i] = 0;
        end else begin
            rpt   = (m_ctl >> 5) & 1;
            sen   = (m_ctl >> 1) & 1;
            presp = m_ctl & 1;
            if (pcix_mode && !ma_posted) act = 3;
            else if (rpt && ma_tabort_ok && !ma_posted) act = 2;
            else if (ma_is_write) act = 1;
            else act = 0;
            ma_serr = (ma_valid && rpt && sen && act < 2) ? 1 : 0;
            fall = (m_secq == 1 && sec_serr_n == 1'b0) ? 1 : 0;
            m_valid = ma_valid;
            if (ma_valid) begin
                m_act = act;
                m_data = (act == 0) ? 64'hFFFF_FFFF : 0;
            end
            m_serr_n = (ma_serr || (fall && sen)) ? 0 : 1;
            m_perr_rep = (perr_strobe && presp) ? 1 : 0;
            if (ma_valid) m_sts[0] = 1; else if (sts_clr[0]) m_sts[0] = 0;
            if (perr_strobe) m_sts[1] = 1; else if (sts_clr[1]) m_sts[1] = 0;
            if (fall) m_sts[2] = 1; else if (sts_clr[2]) m_sts[2] = 0;
            m_secq = sec_serr_n;
            if (ctl_wr_en) m_ctl = ctl_wr_data & 8'h63;
        end
    end

    function automatic string act_req(int a);
        case (a)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            default: return "R5";
        endcase
    endfunction

    task automatic chk(string req, string what, longint act, longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Compare every output with the model once per cycle.
    always @(negedge clk) begin
        if (!done) begin
            chk("R12", "cmpl_valid", cmpl_valid, m_valid);
            if (m_valid) begin
                chk(act_req(m_act), "cmpl_action", cmpl_action, m_act);
                chk(act_req(m_act), "cmpl_data", cmpl_data, m_data);
            end
            chk("R4/R7/R8", "pri_serr_n", pri_serr_n, m_serr_n);
            chk("R6", "perr_report", perr_report, m_perr_rep);
            chk("R9", "sts", sts, {m_sts[2][0], m_sts[1][0], m_sts[0][0]});
            chk("R10", "sec_rst_n", sec_rst_n, ((m_ctl >> 6) & 1) ? 0 : 1);
            chk("R11", "ctl_rd", ctl_rd, m_ctl);
        end
    end

    task automatic tick(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_ctl(logic [7:0] v);
        ctl_wr_en = 1'b1; ctl_wr_data = v;
        tick();
        ctl_wr_en = 1'b0;
    endtask

    task automatic abort(logic wr, logic posted, logic tok);
        ma_valid = 1'b1; ma_is_write = wr; ma_posted = posted; ma_tabort_ok = tok;
        tick();
        ma_valid = 1'b0; ma_is_write = 1'b0; ma_posted = 1'b0; ma_tabort_ok = 1'b0;
        tick(2);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;                       // R12 reset state compared above
        tick(2);
        // R11: all-ones write, reserved bit 4 stays 0; R10 reset asserted
        wr_ctl(8'hFF);
        tick();
        chk("R11", "bit4 after all-ones write", ctl_rd[4], 0);
        chk("R10", "sec_rst_n while bit6 set", sec_rst_n, 0);
        wr_ctl(8'h00);
        tick();
        // R1, R2: quiet mode
        abort(1'b0, 1'b0, 1'b1);
        abort(1'b1, 1'b0, 1'b0);
        abort(1'b1, 1'b1, 1'b0);
        // R3, R4: report mode with SERR disabled
        wr_ctl(8'h20);
        abort(1'b0, 1'b0, 1'b1);
        abort(1'b0, 1'b0, 1'b0);
        abort(1'b1, 1'b1, 1'b1);
        // R4: report mode with SERR enabled
        wr_ctl(8'h22);
        abort(1'b0, 1'b0, 1'b1);
        abort(1'b0, 1'b0, 1'b0);
        abort(1'b1, 1'b1, 1'b0);
        // R5: PCI-X mode, split for non-posted, posted write conventional
        pcix_mode = 1'b1;
        abort(1'b0, 1'b0, 1'b1);
        abort(1'b1, 1'b0, 1'b0);
        abort(1'b1, 1'b1, 1'b0);
        wr_ctl(8'h02);
        abort(1'b0, 1'b0, 1'b0);
        pcix_mode = 1'b0;
        // R12: back-to-back strobes
        ma_valid = 1'b1; ma_is_write = 1'b0;
        tick(3);
        ma_valid = 1'b0;
        tick(2);
        // R6: parity with response disabled, then enabled
        wr_ctl(8'h00);
        perr_strobe = 1'b1; tick(); perr_strobe = 1'b0; tick(2);
        wr_ctl(8'h01);
        perr_strobe = 1'b1; tick(); perr_strobe = 1'b0; tick(2);
        // R7: secondary SERR# with enable off, then on; held low
        wr_ctl(8'h00);
        sec_serr_n = 1'b0; tick(3); sec_serr_n = 1'b1; tick(2);
        wr_ctl(8'h22);
        sec_serr_n = 1'b0; tick(4); sec_serr_n = 1'b1; tick(2);
        // R8: coincident abort report and secondary SERR# edge
        sec_serr_n = 1'b0; ma_valid = 1'b1;
        tick();
        ma_valid = 1'b0;
        tick();
        chk("R8", "merged pulse ends after one cycle", pri_serr_n, 1);
        sec_serr_n = 1'b1;
        tick(2);
        // R11: abort in the same cycle as a control write uses old bits
        ma_valid = 1'b1; ctl_wr_en = 1'b1; ctl_wr_data = 8'h00;
        tick();
        ma_valid = 1'b0; ctl_wr_en = 1'b0;
        tick(2);
        // R9: clear alone, then clear with simultaneous set
        sts_clr = 3'b111; tick(); sts_clr = 3'b000; tick();
        chk("R9", "status cleared", sts, 0);
        ma_valid = 1'b1; perr_strobe = 1'b1; sts_clr = 3'b011;
        tick();
        ma_valid = 1'b0; perr_strobe = 1'b0; sts_clr = 3'b000;
        tick();
        chk("R9", "set wins over clear", sts[1:0], 2'b11);
        // R10: release of secondary reset
        wr_ctl(8'h40); tick(); wr_ctl(8'h00); tick(2);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule